// File: doc/BRIEF.md
# JTAG Shift Engine

This block is the serial heart of a JTAG probe. It makes TCK from the system clock and drives TMS and TDI. It samples TDO and moves one field of 1 to 32 bits through whichever register the target TAP has selected. Each field is described by one command: a data word, a length, a bit-order select, a flag that leaves the Shift state on the last bit, and a flag that then walks the TAP on to Run-Test/Idle. The two flags are separate, so a long scan can be built from several fields issued back to back while the TAP stays in Shift.

The same command port carries three navigation commands. Two of them move from Run-Test/Idle to Shift-IR or to Shift-DR. The third forces the TAP into Test-Logic-Reset from any state and then parks it in Run-Test/Idle. After every command the block returns the word captured from TDO and a one-cycle done pulse. Its busy output guards the command port.

Top module: `jtag_shift_engine`

## Requirements
- R1: A command is taken when `cmd_valid` is high and `busy` is low. `busy` is high from the next cycle up to and including the cycle of the last TCK fall. A command offered while `busy` is high is ignored and does not change any later output. Out of reset `busy`, `done` and `tck` are low, `tms` and `tdi` are high, and `rdata` is zero.
- R2: Let H be the value of `cfg_half` latched when a command is taken, with 0 read as 1. TCK stays low for H clocks after the command is taken, then alternates high and low in phases of H clocks. TCK is low whenever `busy` is low. A change to `cfg_half` during a command has no effect on that command.
- R3: TMS and TDI change only when a command is taken or on a TCK fall. They are stable for the whole time TCK is high.
- R4: Command code 0 shifts a field of `cmd_len` bits (1 to 32). In data cycle k, TDI carries `cmd_data[k]` when `cmd_msb_first` is 0, or `cmd_data[len-1-k]` when it is 1.
- R5: When `cmd_end` is 1, TMS is high in the last data cycle and low in every earlier one. When `cmd_end` is 0, TMS is low in every data cycle and the command ends right after the last data cycle.
- R6: After an ending field, one extra cycle with TMS high moves the TAP to Update. If `cmd_idle` is 1, a further cycle with TMS low follows. `cmd_idle` has no effect when `cmd_end` is 0. TDI is low in these extra cycles.
- R7: The TDO value present at each data-cycle TCK fall is stored at the same bit position its TDI bit came from. Bits at or above `cmd_len` read zero. `rdata` is updated in the done cycle and holds until the next done.
- R8: Command code 1 issues TMS 1,1,0,0 (Run-Test/Idle to Shift-IR). Command code 2 issues TMS 1,0,0 (Run-Test/Idle to Shift-DR). Both hold TDI low and return `rdata` as zero.
- R9: Command code 3 issues TMS high for five TCK cycles and then low for one, with TDI low, and returns `rdata` as zero.
- R10: `done` is a single-cycle pulse in the cycle after the final TCK fall, which comes 2·H·N clocks after the command is taken (N = TCK cycles of the command). A new command may be taken in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | DIV_W | TCK half period in system clocks (0 read as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 shift, 1 to Shift-IR, 2 to Shift-DR, 3 TAP reset |
| cmd_data | input | DATA_W | Field to transmit |
| cmd_len | input | LEN_W | Field length in bits |
| cmd_msb_first | input | 1 | 1 sends the top bit of the field first |
| cmd_end | input | 1 | Leave Shift on the final bit |
| cmd_idle | input | 1 | After leaving Shift, continue to Run-Test/Idle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured TDO field |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG serial data to target |
| tdo | input | 1 | JTAG serial data from target |

## Verification
Completion and the start of a new command can fall in the same cycle. The done pulse and the taking of the next command share the cycle after the final TCK fall. The bench provokes this by raising `cmd_valid` as soon as it sees `done`, and judges it by checking that the new command's first TCK phase starts exactly H clocks later. A second overlap is a command arriving on the very edge on which the previous one finishes. The bench keeps `cmd_valid` high with conflicting fields throughout busy periods, and the reference model expects the field in flight and its `rdata` to be unaffected.

// File: rtl/jse_pkg.sv
package jse_pkg;

  typedef enum logic [1:0] {
    OP_SHIFT     = 2'd0,
    OP_TO_IR     = 2'd1,
    OP_TO_DR     = 2'd2,
    OP_TAP_RESET = 2'd3
  } jse_op_e;

  localparam int TLR_HIGH_CYCLES = 5;

  // Length 0 reads as 1, anything above the data width is cut to it.
  function automatic int clamp_len(int raw, int maxw);
    if (raw == 0) return 1;
    if (raw > maxw) return maxw;
    return raw;
  endfunction

  // Number of TCK cycles a command occupies.
  function automatic int step_count(jse_op_e op, int n, bit fin, bit idle);
    case (op)
      OP_SHIFT:     return n + (fin ? (idle ? 2 : 1) : 0);
      OP_TO_IR:     return 4;
      OP_TO_DR:     return 3;
      default:      return TLR_HIGH_CYCLES + 1;
    endcase
  endfunction

  // TMS level in TCK cycle k of a command.
  function automatic bit step_tms(jse_op_e op, int k, int n, bit fin);
    case (op)
      OP_SHIFT: begin
        if (k < n) return fin && (k == n - 1);
        return k == n;
      end
      OP_TO_IR:     return k < 2;
      OP_TO_DR:     return k == 0;
      default:      return k < TLR_HIGH_CYCLES;
    endcase
  endfunction

  // Bit position of data cycle k within the field.
  function automatic int bit_index(int k, int n, bit msb);
    return msb ? (n - 1 - k) : k;
  endfunction

endpackage

// File: rtl/jse_tck_div.sv
module jse_tck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else if (load) begin
      half_q <= (half_cfg == '0) ? DIV_W'(1) : half_cfg;
      cnt_q  <= '0;
    end else if (run) begin
      cnt_q  <= tick ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/jse_pattern.sv
module jse_pattern
  import jse_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6,
  parameter int STEP_W = 6,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  jse_op_e           op,
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len,
  input  logic              msb,
  input  logic              fin,
  input  logic [STEP_W-1:0] step,
  output logic              tms,
  output logic              tdi
);
  int k, n, ix;

  always_comb begin
    k   = int'(step);
    n   = int'(len);
    ix  = bit_index(k, n, msb);
    tms = step_tms(op, k, n, fin);
    tdi = 1'b0;
    if (op == OP_SHIFT && k < n) tdi = data[IDX_W'(ix)];
  end
endmodule

// File: rtl/jse_step_info.sv
module jse_step_info
  import jse_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6,
  parameter int STEP_W = 6,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  jse_op_e           op,
  input  logic [LEN_W-1:0]  len,
  input  logic              msb,
  input  logic              fin,
  input  logic              idle,
  input  logic [STEP_W-1:0] step,
  output logic              capture,
  output logic [IDX_W-1:0]  idx,
  output logic              last
);
  int k, n;

  always_comb begin
    k       = int'(step);
    n       = int'(len);
    capture = (op == OP_SHIFT) && (k < n);
    idx     = capture ? IDX_W'(bit_index(k, n, msb)) : '0;
    last    = (k == step_count(op, n, fin, idle) - 1);
  end
endmodule

// File: rtl/jse_capture.sv
module jse_capture #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic              bit_in,
  input  logic              commit,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] cap_upd;

  always_comb begin
    cap_upd = cap_q;
    if (strobe) cap_upd[idx] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
      word  <= '0;
    end else begin
      if (clear)       cap_q <= '0;
      else if (strobe) cap_q <= cap_upd;
      if (commit)      word  <= cap_upd;
    end
  end
endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
  import jse_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_msb_first,
  input  logic              cmd_end,
  input  logic              cmd_idle,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int STEP_W = $clog2(DATA_W + 3);

  // Command registers
  jse_op_e           op_q;
  logic [DATA_W-1:0] data_q;
  logic [LEN_W-1:0]  len_q;
  logic              msb_q, fin_q, idle_q;
  logic [STEP_W-1:0] step_q;

  // Line state
  logic busy_q, done_q, tck_q, tms_q, tdi_q;

  // Named events
  logic accept, tick, rise_evt, fall_evt, finish;

  // Step decode
  logic [LEN_W-1:0]  len_in;
  jse_op_e           nx_op;
  logic [DATA_W-1:0] nx_data;
  logic [LEN_W-1:0]  nx_len;
  logic              nx_msb, nx_fin;
  logic [STEP_W-1:0] nx_step;
  logic              nx_tms, nx_tdi;
  logic              cur_capture, cur_last;
  logic [IDX_W-1:0]  cur_idx;

  assign len_in   = LEN_W'(clamp_len(int'(cmd_len), DATA_W));
  assign accept   = cmd_valid && !busy_q;
  assign rise_evt = tick && !tck_q;
  assign fall_evt = tick && tck_q;
  assign finish   = fall_evt && cur_last;

  // The pattern for the next cycle comes from the incoming command on
  // accept, otherwise from the latched command one step ahead.
  assign nx_op   = accept ? jse_op_e'(cmd_op) : op_q;
  assign nx_data = accept ? cmd_data : data_q;
  assign nx_len  = accept ? len_in : len_q;
  assign nx_msb  = accept ? cmd_msb_first : msb_q;
  assign nx_fin  = accept ? cmd_end : fin_q;
  assign nx_step = accept ? '0 : step_q + STEP_W'(1);

  jse_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .run      (busy_q),
    .half_cfg (cfg_half),
    .tick     (tick)
  );

  jse_pattern #(.DATA_W(DATA_W), .LEN_W(LEN_W), .STEP_W(STEP_W)) u_next (
    .op   (nx_op),
    .data (nx_data),
    .len  (nx_len),
    .msb  (nx_msb),
    .fin  (nx_fin),
    .step (nx_step),
    .tms  (nx_tms),
    .tdi  (nx_tdi)
  );

  jse_step_info #(.DATA_W(DATA_W), .LEN_W(LEN_W), .STEP_W(STEP_W)) u_cur (
    .op      (op_q),
    .len     (len_q),
    .msb     (msb_q),
    .fin     (fin_q),
    .idle    (idle_q),
    .step    (step_q),
    .capture (cur_capture),
    .idx     (cur_idx),
    .last    (cur_last)
  );

  jse_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .strobe (fall_evt && cur_capture),
    .idx    (cur_idx),
    .bit_in (tdo),
    .commit (finish),
    .word   (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_SHIFT;
      data_q <= '0;
      len_q  <= LEN_W'(1);
      msb_q  <= 1'b0;
      fin_q  <= 1'b0;
      idle_q <= 1'b0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tck_q  <= 1'b0;
      tms_q  <= 1'b1;
      tdi_q  <= 1'b1;
    end else begin
      done_q <= finish;
      if (accept) begin
        op_q   <= nx_op;
        data_q <= cmd_data;
        len_q  <= len_in;
        msb_q  <= cmd_msb_first;
        fin_q  <= cmd_end;
        idle_q <= cmd_idle;
        step_q <= '0;
        busy_q <= 1'b1;
        tck_q  <= 1'b0;
        tms_q  <= nx_tms;
        tdi_q  <= nx_tdi;
      end else if (busy_q) begin
        if (rise_evt) begin
          tck_q <= 1'b1;
        end else if (fall_evt) begin
          tck_q <= 1'b0;
          if (cur_last) begin
            busy_q <= 1'b0;
          end else begin
            step_q <= nx_step;
            tms_q  <= nx_tms;
            tdi_q  <= nx_tdi;
          end
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign tck  = tck_q;
  assign tms  = tms_q;
  assign tdi  = tdi_q;
endmodule

// File: rtl/jse_checker.sv
module jse_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic finish
);
  a_r1_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid && !finish |=> busy);

  a_r2_tck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  a_r2_tck_rise_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> $past(busy));

  a_r3_lines_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> $stable(tms) && $stable(tdi));

  a_r10_done_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done && !busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind jtag_shift_engine jse_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy_q),
  .done      (done_q),
  .tck       (tck_q),
  .tms       (tms_q),
  .tdi       (tdi_q),
  .finish    (finish)
);

// File: tb/jtag_shift_engine_tb.sv
module jtag_shift_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half = 8'd1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_data = '0;
  logic [5:0]  cmd_len = 6'd1;
  logic        cmd_msb_first = 1'b0;
  logic        cmd_end = 1'b0;
  logic        cmd_idle = 1'b0;
  logic        busy, done, tck, tms, tdi;
  logic [31:0] rdata;
  logic        tdo;
  logic [15:0] lfsr = 16'hACE1;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;  // 125 MHz

  jtag_shift_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_len(cmd_len),
    .cmd_msb_first(cmd_msb_first), .cmd_end(cmd_end), .cmd_idle(cmd_idle),
    .busy(busy), .done(done), .rdata(rdata), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo)
  );

  // Target stand-in: TDO follows a pseudo-random stream, moved away from clk edges.
  assign tdo = lfsr[0];
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  // ---------------- reference model ----------------
  bit          m_busy = 0, m_done = 0;
  int          m_t = 0, m_H = 1, m_N = 0, m_ncap = 0, m_s = 0, m_len = 1;
  logic [31:0] m_cap = '0, m_rdata = '0;
  bit          m_tms_last = 1, m_tdi_last = 1;
  int          e_tms [64];
  int          e_tdi [64];
  int          e_idx [64];

  task automatic push(int tms_v, int tdi_v);
    e_tms[m_N] = tms_v;
    e_tdi[m_N] = tdi_v;
    m_N++;
  endtask

  task automatic model_take();
    m_H  = (cfg_half == 0) ? 1 : int'(cfg_half);
    m_len = (cmd_len == 0) ? 1 : ((cmd_len > 32) ? 32 : int'(cmd_len));
    m_N = 0; m_ncap = 0; m_cap = '0; m_t = 0; m_busy = 1;
    case (cmd_op)
      2'd0: begin
        for (int k = 0; k < m_len; k++) begin
          e_idx[k] = cmd_msb_first ? (m_len - 1 - k) : k;
          push((cmd_end && k == m_len - 1) ? 1 : 0, int'(cmd_data[e_idx[k]]));
        end
        m_ncap = m_len;
        if (cmd_end) begin
          push(1, 0);
          if (cmd_idle) push(0, 0);
        end
      end
      2'd1: begin push(1, 0); push(1, 0); push(0, 0); push(0, 0); end
      2'd2: begin push(1, 0); push(0, 0); push(0, 0); end
      default: begin
        for (int k = 0; k < 5; k++) push(1, 0);
        push(0, 0);
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cap = '0; m_rdata = '0;
      m_tms_last = 1; m_tdi_last = 1;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_t++;
        if (m_t % (2 * m_H) == 0) begin
          m_s = m_t / (2 * m_H) - 1;
          if (m_s < m_ncap) m_cap[e_idx[m_s]] = tdo;
          if (m_s == m_N - 1) begin
            m_busy = 0; m_done = 1; m_rdata = m_cap;
            m_tms_last = e_tms[m_s][0]; m_tdi_last = e_tdi[m_s][0];
          end
        end
      end else if (cmd_valid) begin
        model_take();
      end
    end
  end

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare on every clock, at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      cmp("R1", "busy", 32'(busy), 32'(m_busy));
      cmp("R10", "done", 32'(done), 32'(m_done));
      cmp("R2", "tck", 32'(tck), 32'(m_busy && ((m_t / m_H) % 2 == 1)));
      cmp("R3 R5 R6 R8 R9", "tms", 32'(tms),
          m_busy ? 32'(e_tms[m_t / (2 * m_H)]) : 32'(m_tms_last));
      cmp("R3 R4", "tdi", 32'(tdi),
          m_busy ? 32'(e_tdi[m_t / (2 * m_H)]) : 32'(m_tdi_last));
      cmp("R7", "rdata", rdata, m_rdata);
    end
  end

  // Issue one command (called at a falling edge); optionally keep offering
  // conflicting commands while busy (R1 ignore, R2 divisor latch).
  task automatic run(int op, logic [31:0] d, int len, bit msb, bit fin, bit idl,
                     int h, bit spam);
    cmd_valid = 1; cmd_op = op[1:0]; cmd_data = d; cmd_len = len[5:0];
    cmd_msb_first = msb; cmd_end = fin; cmd_idle = idl; cfg_half = h[7:0];
    @(negedge clk);
    cmd_valid = spam; cmd_data = ~d; cmd_op = 2'(op + 1); cmd_len = 6'd7;
    cmd_msb_first = ~msb; cfg_half = 8'd9;
    while (!m_done) @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R2: reset state
    vectors++;
    if (busy !== 0 || done !== 0 || tck !== 0 || tms !== 1 || tdi !== 1 || rdata !== 0) begin
      miscompares++;
      $display("FAIL R1 R2 reset: actual %b%b%b%b%b %h expected 00011 0", busy, done, tck, tms, tdi, rdata);
    end
    // R9: TAP reset, then R8: to Shift-DR
    run(3, 32'h0, 1, 0, 0, 0, 2, 0);
    @(negedge clk);
    run(2, 32'h0, 1, 0, 0, 0, 1, 0);
    // R4 R5 R6 R7: full-width LSB-first field ending in idle
    run(0, 32'hA5A5_3C0F, 32, 0, 1, 1, 1, 1);
    // R8: to Shift-IR with divisor 0 read as 1 (R2)
    run(1, 32'h0, 1, 0, 0, 0, 0, 0);
    // R6: ending field stopping at Update
    run(0, 32'h0000_000B, 4, 0, 1, 0, 3, 1);
    @(negedge clk);
    // R5: non-ending MSB field, then R10 back-to-back in the done cycle
    run(0, 32'h0000_00C5, 8, 1, 0, 0, 2, 1);
    run(0, 32'h0012_3456, 24, 1, 1, 1, 2, 1);
    // R4 R6: single-bit fields; idle ignored without end
    run(0, 32'h1, 1, 0, 1, 1, 1, 0);
    run(0, 32'h1, 1, 1, 0, 1, 1, 1);
    // R4 R7: full-width MSB-first
    run(0, 32'hDEAD_BEEF, 32, 1, 1, 1, 2, 1);
    run(3, 32'hFFFF_FFFF, 5, 1, 1, 1, 1, 1);
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule